// File: doc/BRIEF.md
# Configurable Probe Trigger Unit

This block watches a small set of probe signals and raises a trigger when one of them matches a condition that software selects at run time. There are three single-bit probes and one multi-bit probe. Each probe has a 16-bit operation register and a 16-bit argument register on a simple memory-mapped register bus. The operation picks the comparison: equality, inequality, the four unsigned orderings, rising edge, falling edge or any change. Code zero, or any code above nine, turns the probe off.

The comparisons run every clock cycle. Each probe is compared with its argument, or with its own value from the cycle before, and the per-probe results are ORed. The result is then registered into a single trigger output for a capture controller. Register reads return data one cycle after the read strobe, with a valid flag.

Top module: `probe_trigger_unit`

## Requirements
- R1: After reset the trigger output is 0, the read-valid output is 0, and every operation and argument register reads back as 0.
- R2: Probe k (k = 0..2 for the single-bit probes in bit order, k = 3 for the 4-bit probe) has its operation register at address 3+2k and its argument register at 3+2k+1. A write stores all 16 bits. A read strobe at edge n gives read-valid high and the stored value on the read data after edge n.
- R3: A read of an address outside 3..10 returns 0 with read-valid high.
- R4: An operation value of 0, or any value above 9, keeps that probe from ever raising the trigger.
- R5: Code 8 hits when the probe equals the argument. Code 9 hits when they differ.
- R6: Code 4 hits on probe < argument, 5 on <=, 6 on >, 7 on >=. All four are unsigned.
- R7: Code 1 hits when any probe bit was 0 in the previous cycle and is 1 now. Code 2 hits on any bit going from 1 to 0. Code 3 hits on any difference from the previous cycle. The previous value is 0 after reset.
- R8: Only the low bits of the argument, as many as the probe is wide, take part in comparisons.
- R9: The trigger output is the OR of all probe hits. It is registered: probe values present at edge n affect the trigger after edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High one cycle after a read strobe |
| probe_bits | input | 3 | The three single-bit probes |
| probe_nib | input | 4 | The 4-bit probe |
| trigger_o | output | 1 | Registered trigger |

## Verification
A corrupted operation or argument register shows up at the port in two ways. The next read of that address returns the wrong value. The trigger also takes the wrong value one cycle after the probe pattern that should have decided it. A stale or wrongly reset previous-value register only shows at the trigger output, one cycle after an edge stimulus. For this reason every probe step is paired with a trigger comparison on the following cycle. Truncation faults need an argument with upper bits set, and those bits must change the result if they are not dropped.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  localparam int REG_W = 16;

  typedef enum logic [3:0] {
    OP_OFF  = 4'd0,
    OP_RISE = 4'd1,
    OP_FALL = 4'd2,
    OP_CHG  = 4'd3,
    OP_LT   = 4'd4,
    OP_LE   = 4'd5,
    OP_GT   = 4'd6,
    OP_GE   = 4'd7,
    OP_EQ   = 4'd8,
    OP_NE   = 4'd9
  } ptu_op_e;

  // Any code above the last defined one maps to OP_OFF.
  function automatic ptu_op_e decode_op(input logic [REG_W-1:0] raw);
    if (raw > REG_W'(OP_NE)) return OP_OFF;
    return ptu_op_e'(raw[3:0]);
  endfunction
endpackage

// File: rtl/ptu_rst_sync.sv
module ptu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/ptu_regs.sv
module ptu_regs #(
  parameter int          NPROBE = 4,
  parameter logic [15:0] BASE   = 16'd3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [15:0]             reg_addr,
  input  logic [15:0]             reg_wdata,
  output logic [15:0]             reg_rdata,
  output logic                    reg_rvalid,
  output logic [NPROBE-1:0][15:0] op_o,
  output logic [NPROBE-1:0][15:0] arg_o
);
  localparam logic [15:0] LAST = BASE + 16'(2*NPROBE - 1);

  logic [NPROBE-1:0][15:0] op_q, arg_q;
  logic [15:0]             rdata_d;
  logic                    mapped;

  genvar g;
  generate
    for (g = 0; g < NPROBE; g++) begin : g_slot
      localparam logic [15:0] OP_ADDR  = BASE + 16'(2*g);
      localparam logic [15:0] ARG_ADDR = BASE + 16'(2*g + 1);
      logic op_en, arg_en;
      assign op_en  = reg_wr && (reg_addr == OP_ADDR);
      assign arg_en = reg_wr && (reg_addr == ARG_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          op_q[g]  <= '0;
          arg_q[g] <= '0;
        end else begin
          if (op_en)  op_q[g]  <= reg_wdata;
          if (arg_en) arg_q[g] <= reg_wdata;
        end
      end
    end
  endgenerate

  assign mapped = (reg_addr >= BASE) && (reg_addr <= LAST);

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NPROBE; i++) begin
      if (reg_addr == BASE + 16'(2*i))     rdata_d = op_q[i];
      if (reg_addr == BASE + 16'(2*i + 1)) rdata_d = arg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rdata_d;
    end
  end

  assign op_o  = op_q;
  assign arg_o = arg_q;

  p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |=> (reg_rdata == 16'd0));
endmodule

// File: rtl/ptu_cmp.sv
module ptu_cmp
  import ptu_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [15:0]  op_raw,
  input  logic [15:0]  arg_raw,
  output logic         hit
);
  logic [W-1:0] prev_q;
  logic [W-1:0] arg_t;
  ptu_op_e      op;

  assign arg_t = arg_raw[W-1:0];
  assign op    = decode_op(op_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  always_comb begin
    unique case (op)
      OP_RISE: hit = |(cur & ~prev_q);
      OP_FALL: hit = |(~cur & prev_q);
      OP_CHG:  hit = (cur != prev_q);
      OP_LT:   hit = (cur <  arg_t);
      OP_LE:   hit = (cur <= arg_t);
      OP_GT:   hit = (cur >  arg_t);
      OP_GE:   hit = (cur >= arg_t);
      OP_EQ:   hit = (cur == arg_t);
      OP_NE:   hit = (cur != arg_t);
      default: hit = 1'b0;
    endcase
  end

  p_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_raw == 16'd0) || (op_raw > 16'd9)) |-> !hit);
  p_steady_no_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_raw == 16'd1 || op_raw == 16'd2 || op_raw == 16'd3) && (cur == prev_q)) |-> !hit);
endmodule

// File: rtl/probe_trigger_unit.sv
module probe_trigger_unit #(
  parameter int          NARROW = 3,
  parameter int          WIDE_W = 4,
  parameter logic [15:0] BASE   = 16'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic [NARROW-1:0] probe_bits,
  input  logic [WIDE_W-1:0] probe_nib,
  output logic              trigger_o
);
  localparam int NPROBE = NARROW + 1;

  logic                    rst_s;
  logic [NPROBE-1:0][15:0] op_w, arg_w;
  logic [NPROBE-1:0]       hit_w;
  logic                    trig_d;
  logic                    all_off;

  ptu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  ptu_regs #(.NPROBE(NPROBE), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .op_o(op_w), .arg_o(arg_w)
  );

  genvar g;
  generate
    for (g = 0; g < NARROW; g++) begin : g_bit
      ptu_cmp #(.W(1)) u_cmp (
        .clk(clk), .rst_n(rst_s), .cur(probe_bits[g]),
        .op_raw(op_w[g]), .arg_raw(arg_w[g]), .hit(hit_w[g])
      );
    end
  endgenerate

  ptu_cmp #(.W(WIDE_W)) u_cmp_wide (
    .clk(clk), .rst_n(rst_s), .cur(probe_nib),
    .op_raw(op_w[NARROW]), .arg_raw(arg_w[NARROW]), .hit(hit_w[NARROW])
  );

  assign trig_d = |hit_w;

  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < NPROBE; i++)
      if (op_w[i] != 16'd0 && op_w[i] <= 16'd9) all_off = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) trigger_o <= 1'b0;
    else        trigger_o <= trig_d;
  end

  p_all_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_s)
    $past(all_off) |-> !trigger_o);
  p_trig_delay_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (|hit_w) |=> trigger_o);
  p_trig_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !(|hit_w) |=> !trigger_o);
endmodule

// File: tb/probe_trigger_unit_tb.sv
module probe_trigger_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic [2:0]  probe_bits;
  logic [3:0]  probe_nib;
  logic        trigger_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];

  logic [15:0] m_op[4];
  logic [15:0] m_arg[4];

  always #4 clk = ~clk;

  probe_trigger_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .probe_bits(probe_bits), .probe_nib(probe_nib),
    .trigger_o(trigger_o)
  );

  function automatic logic model_hit(input logic [15:0] op, input logic [15:0] arg,
                                     input logic [3:0] c, input logic [3:0] p, input int w);
    logic [3:0] mask, a;
    mask = 4'((1 << w) - 1);
    a    = arg[3:0] & mask;
    case (op)
      16'd1: return ((c & ~p) & mask) != 0;
      16'd2: return ((~c & p) & mask) != 0;
      16'd3: return ((c ^ p) & mask) != 0;
      16'd4: return c < a;
      16'd5: return c <= a;
      16'd6: return c > a;
      16'd7: return c >= a;
      16'd8: return c == a;
      16'd9: return c != a;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: applies a probe pattern and queues the trigger expected next cycle.
  task automatic step(input logic [2:0] b, input logic [3:0] n, input string req);
    logic [3:0] cb[4], pb[4];
    logic e;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      cb[k] = {3'b0, b[k]};
      pb[k] = {3'b0, probe_bits[k]};
    end
    cb[3] = n; pb[3] = probe_nib;
    e = 1'b0;
    for (int k = 0; k < 4; k++)
      e |= model_hit(m_op[k], m_arg[k], cb[k], pb[k], (k == 3) ? 4 : 1);
    probe_bits = b;
    probe_nib  = n;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(posedge clk);
  endtask

  // Monitor: compares the trigger with the queued expectation after each edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), {15'd0, trigger_o}, {15'd0, exp_q.pop_front()});
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a >= 3 && a <= 10) begin
      if ((a - 3) % 2 == 0) m_op[(a - 3) / 2] = d;
      else                  m_arg[(a - 3) / 2] = d;
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    #2;
    check({req, " valid"}, {15'd0, reg_rvalid}, 16'd1);
    check(req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clear_all();
    for (int a = 3; a <= 10; a++) wr(16'(a), 16'd0);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    probe_bits = 0; probe_nib = 0;
    for (int k = 0; k < 4; k++) begin m_op[k] = 0; m_arg[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1 trigger", {15'd0, trigger_o}, 16'd0);
    check("R1 rvalid", {15'd0, reg_rvalid}, 16'd0);
    rd(16'd3, 16'd0, "R1 op0");
    rd(16'd10, 16'd0, "R1 arg3");

    // R2: full 16-bit readback at each slot
    wr(16'd3, 16'h1234);
    wr(16'd10, 16'hBEEF);
    wr(16'd6, 16'h00A5);
    rd(16'd3, 16'h1234, "R2 op0");
    rd(16'd10, 16'hBEEF, "R2 arg3");
    rd(16'd6, 16'h00A5, "R2 arg1");
    // R3: unmapped addresses
    rd(16'd2, 16'd0, "R3 below");
    rd(16'd11, 16'd0, "R3 above");
    clear_all();

    // R4: out-of-range codes never trigger
    wr(16'd3, 16'd12); wr(16'd4, 16'd1);
    wr(16'd9, 16'hFFFF); wr(16'd10, 16'd0);
    step(3'b001, 4'd5, "R4");
    step(3'b000, 4'd0, "R4");
    step(3'b001, 4'd9, "R4");
    clear_all();

    // R5: equal / not equal
    wr(16'd3, 16'd8); wr(16'd4, 16'd1);
    step(3'b001, 4'd0, "R5 eq");
    step(3'b000, 4'd0, "R5 eq");
    wr(16'd3, 16'd0);
    wr(16'd9, 16'd9); wr(16'd10, 16'd6);
    step(3'b000, 4'd6, "R5 ne");
    step(3'b000, 4'd7, "R5 ne");
    clear_all();

    // R6: unsigned orderings on the wide probe
    wr(16'd10, 16'd3);
    wr(16'd9, 16'd6);
    step(3'b000, 4'd4, "R6 gt"); step(3'b000, 4'd3, "R6 gt");
    wr(16'd9, 16'd7);
    step(3'b000, 4'd3, "R6 ge"); step(3'b000, 4'd2, "R6 ge");
    wr(16'd9, 16'd4);
    step(3'b000, 4'd2, "R6 lt"); step(3'b000, 4'd3, "R6 lt");
    wr(16'd9, 16'd5);
    step(3'b000, 4'd3, "R6 le"); step(3'b000, 4'd15, "R6 le");
    clear_all();

    // R8: upper argument bits ignored
    wr(16'd9, 16'd8); wr(16'd10, 16'h0015);
    step(3'b000, 4'd5, "R8 wide");
    step(3'b000, 4'd4, "R8 wide");
    wr(16'd9, 16'd0);
    wr(16'd5, 16'd8); wr(16'd6, 16'h0002);
    step(3'b000, 4'd0, "R8 bit");
    step(3'b010, 4'd0, "R8 bit");
    clear_all();

    // R7: edges against the previous cycle
    wr(16'd5, 16'd1);
    step(3'b000, 4'd0, "R7 rise");
    step(3'b010, 4'd0, "R7 rise");
    step(3'b010, 4'd0, "R7 rise");
    step(3'b000, 4'd0, "R7 rise");
    wr(16'd5, 16'd0); wr(16'd7, 16'd2);
    step(3'b100, 4'd0, "R7 fall");
    step(3'b000, 4'd0, "R7 fall");
    step(3'b000, 4'd0, "R7 fall");
    wr(16'd7, 16'd0); wr(16'd9, 16'd3);
    step(3'b000, 4'd6, "R7 chg");
    step(3'b000, 4'd6, "R7 chg");
    wr(16'd9, 16'd1);
    step(3'b000, 4'd1, "R7 rise wide");
    clear_all();

    // R9: OR across probes, one-cycle latency
    wr(16'd3, 16'd8); wr(16'd4, 16'd1);
    wr(16'd9, 16'd8); wr(16'd10, 16'd9);
    step(3'b000, 4'd9, "R9 or");
    step(3'b001, 4'd0, "R9 or");
    step(3'b001, 4'd9, "R9 or");
    step(3'b000, 4'd0, "R9 or");

    repeat (3) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule